// File: doc/BRIEF.md
# Multi-core IPI and mailbox controller

This unit lets up to `NUM_CORES` processor cores interrupt one another and pass small messages. Each core owns a register write port that takes 64-bit commands and a read port that returns its own registers. A core raises an interrupt on another core by writing a send command that names the target core and a vector number. The unit sets the vector's bit in the target's status register, and if that bit is enabled, the target's interrupt line goes high. The target reads its status, then clears the handled bits by writing ones to its clear register.

For messages, every core owns eight 32-bit mailbox words, grouped as four 64-bit slots. A sender writes one 64-bit command that carries the target core, the word index, a 32-bit payload and four byte-keep bits. The unit merges the payload into the target word in a single cycle. A second form of the command names the destination by its byte offset inside the target's register space instead of by a word index.

Commands from all cores that arrive in the same cycle are absorbed together. The write port therefore has no ready signal and never applies back-pressure: a `wr_valid` pulse is a completed write. The read port is a request/response pair. A `rd_req` pulse always returns `rd_valid` with `rd_data` exactly one cycle later, and a read cannot be refused.

Top module: `ipi_mailbox_ctrl`

## Requirements
- R1: A write to offset 0x040 (any width) is an interrupt send. Bits 25:16 of the data are the target core and bits 4:0 are the vector. The command sets bit `vector` of the target's status register, which reads back at offset 0x000.
- R2: A core's `irq` output equals the OR of (status AND enable), taken from the registers one cycle earlier, so it changes in the cycle after status or enable changes. The enable register is at offset 0x004 and is written by the core's own low data word.
- R3: A write to offset 0x00C clears the writer's own status bits wherever the low data word has a one. If a send sets a bit in the same cycle that a clear clears it, the bit ends up set.
- R4: A 64-bit write to offset 0x048 is a mailbox send. It uses target bits 25:16, word index bits 4:2 and payload bits 63:32. Keep bits 30:27 cover bytes 0..3: a one keeps the old byte and a zero takes the payload byte. With all keep bits zero, the whole payload is written.
- R5: A mailbox send or offset send presented as a 32-bit write (`wr_wide`=0) has no effect.
- R6: A 64-bit write to offset 0x158 is an offset send. It uses the same target, payload and keep fields as R4, and the destination byte offset is in data bits 15:0. Only word-aligned offsets 0x020..0x03C, which are mailbox word (offset-0x20)/4, are accepted; any other offset is ignored.
- R7: A send whose target number is at or above `NUM_CORES` is dropped. In particular, it does not alias onto a lower core.
- R8: Writes to any other offset have no effect on any register.
- R9: Sends in the same cycle are all applied. Status sets are ORed together. Mailbox updates are applied in ascending source-core order, so a higher-numbered source wins on the bytes both commands write.
- R10: A read returns data one cycle after `rd_req`, together with `rd_valid`. Offset 0x000 returns status, 0x004 returns enable, and 0x020+8*s returns slot s as {word 2s+1, word 2s}. Every other offset returns zero.
- R11: After reset, all status, enable and mailbox words are zero and every `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | NUM_CORES | Per-core write strobe |
| wr_addr | input | NUM_CORES*12 | Per-core register offset |
| wr_wide | input | NUM_CORES | 1 = full 64-bit write, 0 = 32-bit write |
| wr_data | input | NUM_CORES*64 | Per-core write data |
| rd_req | input | NUM_CORES | Per-core read request |
| rd_addr | input | NUM_CORES*12 | Per-core read offset |
| rd_valid | output | NUM_CORES | Read response strobe |
| rd_data | output | NUM_CORES*64 | Read response data |
| irq | output | NUM_CORES | Per-core interrupt line |

## Verification
The bench targets byte merging with mixed keep bits. A design that inverted the keep sense, or that skipped the merge when the mask is nonzero, would return wrong bytes in the mailbox slot. It sends to core numbers 4 and 5 to catch target decoding that truncates the core field, which would corrupt core 0 or core 1. It also issues 32-bit forms of the 64-bit-only commands and misaligned or out-of-window offsets, which a loose decoder would let through to the mailbox. Simultaneous set and clear of one status bit, simultaneous overlapping mailbox sends, and the one-cycle lag of `irq` expose designs that lose an interrupt, get the merge order wrong, or drive the interrupt combinationally.

// File: rtl/ipi_mbox_pkg.sv
package ipi_mbox_pkg;
  localparam int REG_AW     = 12;
  localparam int CMD_W      = 64;
  localparam int WORD_W     = 32;
  localparam int VEC_W      = 5;
  localparam int CID_LSB    = 16;
  localparam int CID_W      = 10;
  localparam int KEEP_LSB   = 27;
  localparam int BYTES      = WORD_W / 8;
  localparam int MBOX_SLOTS = 4;
  localparam int MBOX_WORDS = 2 * MBOX_SLOTS;
  localparam int WIDX_W     = $clog2(MBOX_WORDS);
  localparam int OFS_W      = 16;

  localparam logic [REG_AW-1:0] OFS_STATUS    = 12'h000;
  localparam logic [REG_AW-1:0] OFS_ENABLE    = 12'h004;
  localparam logic [REG_AW-1:0] OFS_CLEAR     = 12'h00C;
  localparam logic [REG_AW-1:0] OFS_MBOX      = 12'h020;
  localparam logic [REG_AW-1:0] OFS_IPI_SEND  = 12'h040;
  localparam logic [REG_AW-1:0] OFS_MAIL_SEND = 12'h048;
  localparam logic [REG_AW-1:0] OFS_ANY_SEND  = 12'h158;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_IPI  = 2'd1,
    CMD_MBOX = 2'd2
  } cmd_kind_e;

  typedef struct packed {
    cmd_kind_e          kind;
    logic [CID_W-1:0]   tgt;
    logic [VEC_W-1:0]   vec;
    logic [WIDX_W-1:0]  widx;
    logic [BYTES-1:0]   keep;
    logic [WORD_W-1:0]  payload;
  } ipi_cmd_t;
endpackage

// File: rtl/ipi_send_decode.sv
module ipi_send_decode
  import ipi_mbox_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic              valid,
  input  logic [REG_AW-1:0] addr,
  input  logic              wide,
  input  logic [CMD_W-1:0]  data,
  output ipi_cmd_t          cmd,
  output logic              en_we,
  output logic              clr_we
);
  localparam logic [OFS_W-1:0] WIN_LO = OFS_W'(OFS_MBOX);
  localparam logic [OFS_W-1:0] WIN_HI = WIN_LO + OFS_W'(4 * MBOX_WORDS);

  logic [CID_W-1:0] tgt;
  logic             tgt_ok;
  logic [OFS_W-1:0] win_ofs;
  logic [OFS_W-1:0] win_rel;
  logic             win_ok;
  logic             unused_bits;

  assign tgt     = data[CID_LSB +: CID_W];
  assign tgt_ok  = (tgt < CID_W'(NUM_CORES));
  assign win_ofs = data[OFS_W-1:0];
  assign win_rel = win_ofs - WIN_LO;
  assign win_ok  = (win_ofs >= WIN_LO) && (win_ofs < WIN_HI) && (win_ofs[1:0] == 2'b00);
  assign unused_bits = ^{data[31], data[26]};

  assign en_we  = valid && (addr == OFS_ENABLE);
  assign clr_we = valid && (addr == OFS_CLEAR);

  always_comb begin
    cmd         = '0;
    cmd.kind    = CMD_NONE;
    cmd.tgt     = tgt;
    cmd.vec     = data[VEC_W-1:0];
    cmd.keep    = data[KEEP_LSB +: BYTES];
    cmd.payload = data[CMD_W-1 -: WORD_W];
    cmd.widx    = data[2 +: WIDX_W];
    if (valid && tgt_ok) begin
      if (addr == OFS_IPI_SEND) begin
        cmd.kind = CMD_IPI;
      end else if (wide && (addr == OFS_MAIL_SEND)) begin
        cmd.kind = CMD_MBOX;
      end else if (wide && (addr == OFS_ANY_SEND) && win_ok) begin
        cmd.kind = CMD_MBOX;
        cmd.widx = win_rel[2 +: WIDX_W];
      end
    end
  end
endmodule

// File: rtl/ipi_target_bank.sv
module ipi_target_bank
  import ipi_mbox_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_IDX  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ipi_cmd_t          cmds [NUM_CORES],
  input  logic              en_we,
  input  logic              clr_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rd_req,
  input  logic [REG_AW-1:0] rd_addr,
  output logic              rd_valid,
  output logic [CMD_W-1:0]  rd_data,
  output logic              irq
);
  logic [WORD_W-1:0] status_q, status_d, enable_q, enable_d, set_mask;
  logic [WORD_W-1:0] mbox_q [MBOX_WORDS];
  logic [WORD_W-1:0] mbox_d [MBOX_WORDS];
  logic [CMD_W-1:0]  rd_word;

  // Sources are folded in ascending order: a later source overwrites bytes.
  always_comb begin
    set_mask = '0;
    mbox_d   = mbox_q;
    for (int s = 0; s < NUM_CORES; s++) begin
      if (cmds[s].tgt == CID_W'(CORE_IDX)) begin
        if (cmds[s].kind == CMD_IPI) begin
          set_mask[cmds[s].vec] = 1'b1;
        end
        if (cmds[s].kind == CMD_MBOX) begin
          for (int b = 0; b < BYTES; b++) begin
            if (!cmds[s].keep[b]) begin
              mbox_d[cmds[s].widx][8*b +: 8] = cmds[s].payload[8*b +: 8];
            end
          end
        end
      end
    end
    status_d = (status_q & ~(clr_we ? wdata : '0)) | set_mask;
    enable_d = en_we ? wdata : enable_q;
  end

  always_comb begin
    rd_word = '0;
    if (rd_addr == OFS_STATUS) begin
      rd_word = {{(CMD_W-WORD_W){1'b0}}, status_q};
    end else if (rd_addr == OFS_ENABLE) begin
      rd_word = {{(CMD_W-WORD_W){1'b0}}, enable_q};
    end else begin
      for (int k = 0; k < MBOX_SLOTS; k++) begin
        if (rd_addr == OFS_MBOX + REG_AW'(8 * k)) begin
          rd_word = {mbox_q[2*k+1], mbox_q[2*k]};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      irq      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      for (int w = 0; w < MBOX_WORDS; w++) mbox_q[w] <= '0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      irq      <= |(status_q & enable_q);
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_word;
      for (int w = 0; w < MBOX_WORDS; w++) mbox_q[w] <= mbox_d[w];
    end
  end
endmodule

// File: rtl/ipi_mailbox_ctrl.sv
module ipi_mailbox_ctrl
  import ipi_mbox_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CORES-1:0]        wr_valid,
  input  logic [NUM_CORES*REG_AW-1:0] wr_addr,
  input  logic [NUM_CORES-1:0]        wr_wide,
  input  logic [NUM_CORES*CMD_W-1:0]  wr_data,
  input  logic [NUM_CORES-1:0]        rd_req,
  input  logic [NUM_CORES*REG_AW-1:0] rd_addr,
  output logic [NUM_CORES-1:0]        rd_valid,
  output logic [NUM_CORES*CMD_W-1:0]  rd_data,
  output logic [NUM_CORES-1:0]        irq
);
  ipi_cmd_t             cmds [NUM_CORES];
  logic [NUM_CORES-1:0] en_we;
  logic [NUM_CORES-1:0] clr_we;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_src
    ipi_send_decode #(.NUM_CORES(NUM_CORES)) i_dec (
      .valid  (wr_valid[c]),
      .addr   (wr_addr[c*REG_AW +: REG_AW]),
      .wide   (wr_wide[c]),
      .data   (wr_data[c*CMD_W +: CMD_W]),
      .cmd    (cmds[c]),
      .en_we  (en_we[c]),
      .clr_we (clr_we[c])
    );
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_bank
    ipi_target_bank #(.NUM_CORES(NUM_CORES), .CORE_IDX(c)) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmds     (cmds),
      .en_we    (en_we[c]),
      .clr_we   (clr_we[c]),
      .wdata    (wr_data[c*CMD_W +: WORD_W]),
      .rd_req   (rd_req[c]),
      .rd_addr  (rd_addr[c*REG_AW +: REG_AW]),
      .rd_valid (rd_valid[c]),
      .rd_data  (rd_data[c*CMD_W +: CMD_W]),
      .irq      (irq[c])
    );
  end
endmodule

// File: rtl/ipi_mailbox_ctrl_chk.sv
module ipi_mailbox_ctrl_chk
  import ipi_mbox_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_CORES-1:0]        wr_valid,
  input logic [NUM_CORES*REG_AW-1:0] wr_addr,
  input logic [NUM_CORES-1:0]        wr_wide,
  input logic [NUM_CORES*CMD_W-1:0]  wr_data,
  input logic [NUM_CORES-1:0]        rd_req,
  input logic [NUM_CORES*REG_AW-1:0] rd_addr,
  input logic [NUM_CORES-1:0]        rd_valid,
  input logic [NUM_CORES*CMD_W-1:0]  rd_data,
  input logic [NUM_CORES-1:0]        irq
);
  logic [NUM_CORES-1:0] ipi_to, en_wr, clr_all;

  always_comb begin
    ipi_to  = '0;
    en_wr   = '0;
    clr_all = '0;
    for (int s = 0; s < NUM_CORES; s++) begin
      for (int t = 0; t < NUM_CORES; t++) begin
        if (wr_valid[s] && (wr_addr[s*REG_AW +: REG_AW] == OFS_IPI_SEND) &&
            (wr_data[s*CMD_W + CID_LSB +: CID_W] == CID_W'(t)))
          ipi_to[t] = 1'b1;
      end
      en_wr[s]   = wr_valid[s] && (wr_addr[s*REG_AW +: REG_AW] == OFS_ENABLE);
      clr_all[s] = wr_valid[s] && (wr_addr[s*REG_AW +: REG_AW] == OFS_CLEAR) &&
                   (wr_data[s*CMD_W +: WORD_W] == '1);
    end
  end

  for (genvar t = 0; t < NUM_CORES; t++) begin : g_chk
    // R2: an interrupt only rises two cycles after a send to it or an enable write
    p_irq_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[t]) |-> $past(ipi_to[t] || en_wr[t], 2));
    // R3: clearing every bit with no competing send drops the line
    p_irq_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all[t] && !ipi_to[t]) |=> ##1 !irq[t]);
    // R10: one response per request, one cycle later
    p_rd_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req[t] |=> rd_valid[t]);
    p_rd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req[t] |=> !rd_valid[t]);
    // R11: lines are low as reset is released
    p_irq_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq[t]);
  end
endmodule

bind ipi_mailbox_ctrl ipi_mailbox_ctrl_chk #(.NUM_CORES(NUM_CORES)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_addr  (wr_addr),
  .wr_wide  (wr_wide),
  .wr_data  (wr_data),
  .rd_req   (rd_req),
  .rd_addr  (rd_addr),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .irq      (irq)
);

// File: tb/test_ipi_mailbox_ctrl.sv
module test_ipi_mailbox_ctrl;
  localparam int N  = 4;
  localparam int AW = 12;
  localparam int DW = 64;

  typedef struct packed {
    logic [1:0]    src;
    logic [AW-1:0] addr;
    logic          wide;
    logic [DW-1:0] data;
    logic [1:0]    rcore;
    logic [AW-1:0] raddr;
    logic [DW-1:0] exp;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 12'h040, 1'b0, 64'h0000_0000_0001_0003, 2'd1, 12'h000, 64'h0000_0000_0000_0008, 4'd1},  // R1
    '{2'd2, 12'h040, 1'b1, 64'h0000_0000_0001_001F, 2'd1, 12'h000, 64'h0000_0000_8000_0008, 4'd1},  // R1
    '{2'd1, 12'h004, 1'b0, 64'h0000_0000_0000_0008, 2'd1, 12'h004, 64'h0000_0000_0000_0008, 4'd2},  // R2
    '{2'd1, 12'h00C, 1'b0, 64'h0000_0000_0000_0008, 2'd1, 12'h000, 64'h0000_0000_8000_0000, 4'd3},  // R3
    '{2'd0, 12'h048, 1'b1, 64'hAABB_CCDD_0002_0004, 2'd2, 12'h020, 64'hAABB_CCDD_0000_0000, 4'd4},  // R4
    '{2'd3, 12'h048, 1'b1, 64'h1122_3344_2802_0004, 2'd2, 12'h020, 64'h11BB_33DD_0000_0000, 4'd4},  // R4
    '{2'd0, 12'h048, 1'b0, 64'h0000_0055_0002_0000, 2'd2, 12'h020, 64'h11BB_33DD_0000_0000, 4'd5},  // R5
    '{2'd1, 12'h158, 1'b1, 64'hCAFE_F00D_0003_0038, 2'd3, 12'h038, 64'h0000_0000_CAFE_F00D, 4'd6},  // R6
    '{2'd1, 12'h158, 1'b1, 64'h0000_0001_0003_0010, 2'd3, 12'h020, 64'h0000_0000_0000_0000, 4'd6},  // R6
    '{2'd1, 12'h158, 1'b1, 64'h1234_5678_0003_003A, 2'd3, 12'h038, 64'h0000_0000_CAFE_F00D, 4'd6},  // R6
    '{2'd2, 12'h158, 1'b0, 64'h5555_5555_0003_0038, 2'd3, 12'h038, 64'h0000_0000_CAFE_F00D, 4'd5},  // R5
    '{2'd0, 12'h048, 1'b1, 64'h1234_5678_0004_0000, 2'd0, 12'h020, 64'h0000_0000_0000_0000, 4'd7},  // R7
    '{2'd3, 12'h040, 1'b0, 64'h0000_0000_0005_0002, 2'd1, 12'h000, 64'h0000_0000_8000_0000, 4'd7},  // R7
    '{2'd1, 12'h050, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 12'h004, 64'h0000_0000_0000_0008, 4'd8},  // R8
    '{2'd0, 12'h044, 1'b1, 64'h0000_0000_0001_0009, 2'd1, 12'h000, 64'h0000_0000_8000_0000, 4'd8},  // R8
    '{2'd0, 12'h050, 1'b0, 64'h0000_0000_0000_0000, 2'd0, 12'h010, 64'h0000_0000_0000_0000, 4'd10}  // R10
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    wr_valid = '0;
  logic [N*AW-1:0] wr_addr = '0;
  logic [N-1:0]    wr_wide = '0;
  logic [N*DW-1:0] wr_data = '0;
  logic [N-1:0]    rd_req = '0;
  logic [N*AW-1:0] rd_addr = '0;
  logic [N-1:0]    rd_valid;
  logic [N*DW-1:0] rd_data;
  logic [N-1:0]    irq;

  int n_checks = 0;
  int n_errs   = 0;

  always #2 clk = ~clk;

  ipi_mailbox_ctrl #(.NUM_CORES(N)) i_ipi_mailbox_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_wide(wr_wide), .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic stage_wr(input int src, input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
    wr_valid[src]          = 1'b1;
    wr_addr[src*AW +: AW]  = a;
    wr_wide[src]           = w;
    wr_data[src*DW +: DW]  = d;
  endtask

  task automatic tick();
    @(negedge clk);
    wr_valid = '0;
    rd_req   = '0;
  endtask

  task automatic read_reg(input int core, input logic [AW-1:0] a, output logic [DW-1:0] d,
                          output logic v);
    rd_req[core]          = 1'b1;
    rd_addr[core*AW +: AW] = a;
    tick();
    d = rd_data[core*DW +: DW];
    v = rd_valid[core];
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    logic          v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 irq after reset", {60'd0, irq}, 64'd0);
    read_reg(0, 12'h000, d, v);
    check("R11 status after reset", d, 64'd0);
    read_reg(2, 12'h038, d, v);
    check("R11 mailbox after reset", d, 64'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      stage_wr(int'(VECS[i].src), VECS[i].addr, VECS[i].wide, VECS[i].data);
      tick();
      read_reg(int'(VECS[i].rcore), VECS[i].raddr, d, v);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), d, VECS[i].exp);
    end

    // R10 response strobe
    read_reg(1, 12'h004, d, v);
    check("R10 rd_valid one cycle after request", {63'd0, v}, 64'd1);
    @(negedge clk);
    check("R10 rd_valid drops", {60'd0, rd_valid}, 64'd0);

    // R2 irq lags status by one cycle
    stage_wr(0, 12'h004, 1'b0, 64'hFFFF_FFFF);
    tick();
    stage_wr(1, 12'h040, 1'b0, 64'h0000_0000_0000_0000);
    tick();
    check("R2 irq still low in status cycle", {63'd0, irq[0]}, 64'd0);
    tick();
    check("R2 irq high one cycle later", {63'd0, irq[0]}, 64'd1);

    // R3 set beats clear in the same cycle
    stage_wr(0, 12'h00C, 1'b0, 64'h1);
    stage_wr(2, 12'h040, 1'b0, 64'h0000_0000_0000_0000);
    tick();
    read_reg(0, 12'h000, d, v);
    check("R3 simultaneous set wins", d, 64'h1);

    // R3 clear all, irq falls one cycle after status
    stage_wr(0, 12'h00C, 1'b0, 64'hFFFF_FFFF);
    tick();
    check("R3 irq holds in clear cycle", {63'd0, irq[0]}, 64'd1);
    tick();
    check("R3 irq low after clear", {63'd0, irq[0]}, 64'd0);
    read_reg(0, 12'h000, d, v);
    check("R3 status cleared", d, 64'd0);

    // R9 overlapping mailbox sends: source 3 applied after source 0
    stage_wr(0, 12'h048, 1'b1, 64'h1111_1111_0001_0000);
    stage_wr(3, 12'h048, 1'b1, 64'h2222_2222_0801_0000);
    tick();
    read_reg(1, 12'h020, d, v);
    check("R9 ordered mailbox merge", d, 64'h0000_0000_2222_2211);

    // R9 two interrupt sends to one target in one cycle
    stage_wr(1, 12'h040, 1'b0, 64'h0000_0000_0002_0004);
    stage_wr(2, 12'h040, 1'b0, 64'h0000_0000_0002_0005);
    tick();
    read_reg(2, 12'h000, d, v);
    check("R9 both status bits set", d, 64'h30);

    finish_run();
  end
endmodule